// File: doc/BRIEF.md
# Bytecode Sequencer with Register-Mapped Program Counter

This block steps through a small bytecode program one instruction per clock. Its working registers form a 256-cell data segment held inside the block. Two of those cells have fixed roles. Cell 0xFF holds the program counter and cell 0xFD holds the return link. Cell 0 can never hold anything except zero. Because the program counter is an ordinary cell, any instruction that names it as a destination redirects control flow. The two conditional branches turn into an unconditional jump, a no-op, a call or a return, depending only on which cells they name.

Each instruction has four fields: an opcode byte, a destination cell byte (DEST), a 16-bit source operand (SRC), and a mode bit. The mode bit selects absolute or relative addressing. In relative mode, the upper SRC byte names a cell, and that cell's contents supply the operand or the code address. In relative mode the lower SRC byte names a second cell, which the arithmetic port uses. The block performs loads, stores, immediate moves, branches and halt itself, using a combinational code-segment port. Every arithmetic or logic opcode goes to an external ALU port, and the ALU's answer is written back to the destination cell in the same cycle.

A `start` pulse clears the done flag, sets the program counter to zero and begins execution. The other cells keep their values across a `start` pulse.

Top module: `bc_sequencer`

## Requirements
- R1: Reset leaves the block idle. While idle, `done` is 0, `cs_we` and `alu_valid` are 0, and `instr_addr` is 0. A one-cycle `start` pulse sets the program counter to 0 and clears `done`. It keeps every other cell. The instruction at address 0 then executes in the next cycle.
- R2: Each executed instruction advances the program counter by one. During execution, reading cell 0xFF returns the address of the next instruction.
- R3: `instr_data` is packed as {mode[32], opcode[31:24], DEST[23:16], SRC[15:0]}, and mode 1 means relative. Opcode 3 writes SRC into cell DEST in absolute mode. In relative mode it copies cell SRC[15:8] into cell DEST.
- R4: Opcode 1 drives `cs_addr` with SRC in absolute mode, or with cell SRC[15:8] in relative mode. It then writes `cs_rdata` into cell DEST.
- R5: Opcode 2 raises `cs_we` for exactly its own cycle. It drives `cs_wdata` with cell DEST. It drives `cs_addr` with SRC in absolute mode, or with cell SRC[15:8] in relative mode.
- R6: Cell 0 always reads as zero, and writes to it are discarded.
- R7: Opcode 27 branches when cell DEST is nonzero. A taken branch stores the next-instruction address in cell 0xFD. It then loads the program counter with `cs_rdata` read at address SRC (absolute), or with cell SRC[15:8] (relative). With DEST = 0 it never branches.
- R8: Opcode 28 branches when cell DEST is zero, and saves the link in the same way. With DEST = 0 it always branches.
- R9: Opcode 29 sets `done` and stops execution. After that, the program counter holds, and neither `cs_we` nor `alu_valid` rises until the next `start`.
- R10: For opcodes 4 to 12 and 14 to 26, `alu_valid` is 1 and `alu_op` carries the opcode. In absolute mode `alu_a` is cell DEST and `alu_b` is SRC. In relative mode they are cells SRC[15:8] and SRC[7:0]. `alu_result` is written into cell DEST.
- R11: Any other opcode, including 0, 13 and 30, changes no cell except the program counter.
- R12: An instruction that writes cell 0xFF overrides that cycle's program-counter increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Restart pulse: program counter to 0, clear done, run |
| instr_addr | output | CAW | Address of the instruction being executed |
| instr_data | input | 33 | Instruction {mode, opcode, DEST, SRC} at `instr_addr` |
| cs_addr | output | CAW | Code-segment address for load, store and absolute branch target |
| cs_rdata | input | DW | Code-segment read data (combinational) |
| cs_we | output | 1 | Code-segment write strobe |
| cs_wdata | output | DW | Code-segment write data |
| alu_valid | output | 1 | An arithmetic/logic opcode is being executed |
| alu_op | output | 8 | Opcode passed to the ALU |
| alu_a | output | DW | First ALU operand |
| alu_b | output | DW | Second ALU operand |
| alu_result | input | DW | ALU answer, written back to cell DEST |
| done | output | 1 | Halt reached |

## Verification
Two updates of the program-counter cell can land on the same clock edge. One is the automatic increment. The other is a write that names cell 0xFF, either an immediate move into it or the target load of a taken branch, which also writes the link cell in that cycle. The bench provokes these collisions by moving a constant into cell 0xFF, by taking branches in both polarities, and by a return that jumps through the link cell. It judges each one by the `instr_addr` of the following cycle, and by storing cell 0xFD and cell 0xFF to the code port so that their values can be compared at `cs_wdata`.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
   localparam int IW = 33;

   localparam logic [7:0] OP_LOAD  = 8'd1;
   localparam logic [7:0] OP_STORE = 8'd2;
   localparam logic [7:0] OP_MOVE  = 8'd3;
   localparam logic [7:0] OP_BNZ   = 8'd27;
   localparam logic [7:0] OP_BZ    = 8'd28;
   localparam logic [7:0] OP_HALT  = 8'd29;

   typedef enum logic [2:0] {
      K_NOP, K_LOAD, K_STORE, K_MOVE, K_ALU, K_BNZ, K_BZ, K_HALT
   } kind_e;

   typedef struct packed {
      logic        rel;
      logic [7:0]  op;
      logic [7:0]  dst;
      logic [15:0] src;
   } instr_t;

   function automatic logic goes_to_alu(input logic [7:0] op);
      return ((op >= 8'd4) && (op <= 8'd12)) || ((op >= 8'd14) && (op <= 8'd26));
   endfunction
endpackage

// File: rtl/bcs_decode.sv
module bcs_decode
   import bcs_pkg::*;
(
   input  logic [IW-1:0] word,
   output instr_t        fields,
   output kind_e         kind
);
   always_comb begin
      fields = instr_t'(word);
      unique case (fields.op)
         OP_LOAD:  kind = K_LOAD;
         OP_STORE: kind = K_STORE;
         OP_MOVE:  kind = K_MOVE;
         OP_BNZ:   kind = K_BNZ;
         OP_BZ:    kind = K_BZ;
         OP_HALT:  kind = K_HALT;
         default:  kind = goes_to_alu(fields.op) ? K_ALU : K_NOP;
      endcase
   end
endmodule

// File: rtl/bcs_dseg.sv
module bcs_dseg #(
   parameter int          DW        = 16,
   parameter int          NCELL     = 256,
   parameter logic [7:0]  PC_CELL   = 8'hFF,
   parameter logic [7:0]  LINK_CELL = 8'hFD
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          step,
   input  logic          wr_en,
   input  logic [7:0]    wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          br_en,
   input  logic [DW-1:0] br_target,
   input  logic [7:0]    ra0,
   input  logic [7:0]    ra1,
   input  logic [7:0]    ra2,
   output logic [DW-1:0] rd0,
   output logic [DW-1:0] rd1,
   output logic [DW-1:0] rd2,
   output logic [DW-1:0] pc,
   output logic [DW-1:0] link
);
   logic [DW-1:0] view [NCELL];
   logic [DW-1:0] pc_next_seq;

   assign view[0]     = '0;
   assign pc          = view[PC_CELL];
   assign link        = view[LINK_CELL];
   assign pc_next_seq = pc + DW'(1);

   for (genvar g = 1; g < NCELL; g++) begin : g_cell
      logic [DW-1:0] q;
      wire           hit = wr_en && (wr_addr == 8'(g));
      if (g == int'(PC_CELL)) begin : g_pc
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q <= '0;
            else if (restart) q <= '0;
            else if (hit)     q <= wr_data;
            else if (br_en)   q <= br_target;
            else if (step)    q <= pc_next_seq;
         end
      end else if (g == int'(LINK_CELL)) begin : g_link
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q <= '0;
            else if (br_en) q <= pc_next_seq;
            else if (hit)   q <= wr_data;
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wr_data;
         end
      end
      assign view[g] = q;
   end

   function automatic logic [DW-1:0] rd(input logic [7:0] a);
      return (a == PC_CELL) ? pc_next_seq : view[a];
   endfunction

   assign rd0 = rd(ra0);
   assign rd1 = rd(ra1);
   assign rd2 = rd(ra2);
endmodule

// File: rtl/bc_sequencer.sv
module bc_sequencer
   import bcs_pkg::*;
#(
   parameter int DW  = 16,
   parameter int CAW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   output logic [CAW-1:0] instr_addr,
   input  logic [IW-1:0]  instr_data,
   output logic [CAW-1:0] cs_addr,
   input  logic [DW-1:0]  cs_rdata,
   output logic           cs_we,
   output logic [DW-1:0]  cs_wdata,
   output logic           alu_valid,
   output logic [7:0]     alu_op,
   output logic [DW-1:0]  alu_a,
   output logic [DW-1:0]  alu_b,
   input  logic [DW-1:0]  alu_result,
   output logic           done
);
   localparam logic [7:0] PC_CELL   = 8'hFF;
   localparam logic [7:0] LINK_CELL = 8'hFD;

   if (DW < 16) begin : g_bad_dw
      $error("DW must hold a 16-bit SRC operand");
   end
   if (CAW > DW) begin : g_bad_caw
      $error("CAW must not exceed DW");
   end

   instr_t        ins;
   kind_e         kind;
   logic          run, exe, take, wr_en, cond_nz;
   logic [DW-1:0] rd0, rd1, rd2, pc, link, wr_data, br_target, src_ext;

   bcs_decode u_dec (.word(instr_data), .fields(ins), .kind(kind));

   assign exe     = run && !start;
   assign src_ext = DW'(ins.src);
   assign cond_nz = (rd0 != '0);
   assign take    = exe && (((kind == K_BNZ) && cond_nz) || ((kind == K_BZ) && !cond_nz));

   assign cs_addr   = ins.rel ? rd1[CAW-1:0] : ins.src[CAW-1:0];
   assign br_target = ins.rel ? rd1 : cs_rdata;
   assign cs_we     = exe && (kind == K_STORE);
   assign cs_wdata  = rd0;

   assign alu_valid = exe && (kind == K_ALU);
   assign alu_op    = ins.op;
   assign alu_a     = ins.rel ? rd1 : rd0;
   assign alu_b     = ins.rel ? rd2 : src_ext;

   assign wr_en = exe && ((kind == K_LOAD) || (kind == K_MOVE) || (kind == K_ALU));
   always_comb begin
      unique case (kind)
         K_LOAD:  wr_data = cs_rdata;
         K_ALU:   wr_data = alu_result;
         default: wr_data = ins.rel ? rd1 : src_ext;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= 1'b0;
         done <= 1'b0;
      end else if (start) begin
         run  <= 1'b1;
         done <= 1'b0;
      end else if (exe && (kind == K_HALT)) begin
         run  <= 1'b0;
         done <= 1'b1;
      end
   end

   bcs_dseg #(.DW(DW), .NCELL(256), .PC_CELL(PC_CELL), .LINK_CELL(LINK_CELL)) u_ds (
      .clk(clk), .rst_n(rst_n), .restart(start), .step(exe),
      .wr_en(wr_en), .wr_addr(ins.dst), .wr_data(wr_data),
      .br_en(take), .br_target(br_target),
      .ra0(ins.dst), .ra1(ins.src[15:8]), .ra2(ins.src[7:0]),
      .rd0(rd0), .rd1(rd1), .rd2(rd2), .pc(pc), .link(link)
   );

   assign instr_addr = pc[CAW-1:0];
endmodule

// File: rtl/bc_sequencer_chk.sv
module bc_sequencer_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          run,
   input logic          done,
   input logic          cs_we,
   input logic          alu_valid,
   input logic          take,
   input logic          halting,
   input logic          pc_written,
   input logic [DW-1:0] pc,
   input logic [DW-1:0] link
);
   p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (pc == '0) && !done && run);

   p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !start && !take && !pc_written) |=> (pc == $past(pc) + DW'(1)));

   p_link_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (link == $past(pc) + DW'(1)));

   p_halt_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (halting && !start) |=> (done && !run));

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (!cs_we && !alu_valid));

   p_halt_holds_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !start) |=> $stable(pc));
endmodule

bind bc_sequencer bc_sequencer_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .run(run), .done(done),
   .cs_we(cs_we), .alu_valid(alu_valid), .take(take),
   .halting(exe && (kind == bcs_pkg::K_HALT)),
   .pc_written(wr_en && (ins.dst == PC_CELL)),
   .pc(pc), .link(link)
);

// File: tb/bc_sequencer_bench.sv
module bc_sequencer_bench;
   localparam int DW = 16;
   localparam int CAW = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [CAW-1:0] instr_addr;
   logic [32:0]    instr_data = '0;
   logic [CAW-1:0] cs_addr;
   logic [DW-1:0]  cs_rdata;
   logic           cs_we;
   logic [DW-1:0]  cs_wdata;
   logic           alu_valid;
   logic [7:0]     alu_op;
   logic [DW-1:0]  alu_a, alu_b, alu_result;
   logic           done;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   bc_sequencer #(.DW(DW), .CAW(CAW)) u_bc_sequencer (
      .clk(clk), .rst_n(rst_n), .start(start),
      .instr_addr(instr_addr), .instr_data(instr_data),
      .cs_addr(cs_addr), .cs_rdata(cs_rdata), .cs_we(cs_we), .cs_wdata(cs_wdata),
      .alu_valid(alu_valid), .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b),
      .alu_result(alu_result), .done(done)
   );

   logic [DW-1:0] cs_mem [64];
   initial for (int i = 0; i < 64; i++) cs_mem[i] = 16'h1000 + 16'(i);
   always @(posedge clk) if (cs_we) cs_mem[cs_addr[5:0]] <= cs_wdata;
   assign cs_rdata   = cs_mem[cs_addr[5:0]];
   assign alu_result = alu_a + alu_b + DW'(alu_op);

   typedef struct packed {
      logic        rel;
      logic [7:0]  op;
      logic [7:0]  dst;
      logic [15:0] src;
      logic [15:0] pc;
      logic        we;
      logic [15:0] addr;
      logic [15:0] wd;
      logic        alu;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 29;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 8'd3,  8'h01, 16'h1234, 16'h0000, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd3},  // R3 imm
      '{1'b0, 8'd2,  8'h01, 16'h0010, 16'h0001, 1'b1, 16'h0010, 16'h1234, 1'b0, 4'd5},  // R5 abs
      '{1'b0, 8'd3,  8'h02, 16'h0005, 16'h0002, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd3},
      '{1'b1, 8'd3,  8'h03, 16'h0100, 16'h0003, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd3},  // R3 copy
      '{1'b1, 8'd2,  8'h03, 16'h0200, 16'h0004, 1'b1, 16'h0005, 16'h1234, 1'b0, 4'd5},  // R5 rel
      '{1'b0, 8'd1,  8'h04, 16'h0007, 16'h0005, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd4},  // R4 abs
      '{1'b0, 8'd2,  8'h04, 16'h0020, 16'h0006, 1'b1, 16'h0020, 16'h1007, 1'b0, 4'd4},
      '{1'b1, 8'd1,  8'h06, 16'h0200, 16'h0007, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd4},  // R4 rel
      '{1'b0, 8'd2,  8'h06, 16'h0021, 16'h0008, 1'b1, 16'h0021, 16'h1234, 1'b0, 4'd4},
      '{1'b0, 8'd3,  8'h00, 16'hBEEF, 16'h0009, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd6},  // R6
      '{1'b0, 8'd2,  8'h00, 16'h0022, 16'h000A, 1'b1, 16'h0022, 16'h0000, 1'b0, 4'd6},
      '{1'b0, 8'd14, 8'h01, 16'h0003, 16'h000B, 1'b0, 16'h0000, 16'h0000, 1'b1, 4'd10}, // R10 abs
      '{1'b0, 8'd2,  8'h01, 16'h0023, 16'h000C, 1'b1, 16'h0023, 16'h1245, 1'b0, 4'd10},
      '{1'b1, 8'd6,  8'h07, 16'h0102, 16'h000D, 1'b0, 16'h0000, 16'h0000, 1'b1, 4'd10}, // R10 rel
      '{1'b0, 8'd2,  8'h07, 16'h0024, 16'h000E, 1'b1, 16'h0024, 16'h1250, 1'b0, 4'd10},
      '{1'b0, 8'd13, 8'h01, 16'h9999, 16'h000F, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd11}, // R11
      '{1'b0, 8'd30, 8'h01, 16'h9999, 16'h0010, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd11},
      '{1'b0, 8'd2,  8'h01, 16'h0025, 16'h0011, 1'b1, 16'h0025, 16'h1245, 1'b0, 4'd11},
      '{1'b0, 8'd27, 8'h00, 16'h0030, 16'h0012, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd7},  // R7 no-op
      '{1'b0, 8'd27, 8'h02, 16'h0008, 16'h0013, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd7},  // R7 taken
      '{1'b0, 8'd2,  8'hFD, 16'h0026, 16'h1008, 1'b1, 16'h0026, 16'h0014, 1'b0, 4'd7},
      '{1'b0, 8'd28, 8'h02, 16'h0030, 16'h1009, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd8},  // R8 not taken
      '{1'b0, 8'd3,  8'h08, 16'h0040, 16'h100A, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd8},
      '{1'b1, 8'd28, 8'h00, 16'h0800, 16'h100B, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd8},  // R8 call
      '{1'b0, 8'd2,  8'hFD, 16'h0027, 16'h0040, 1'b1, 16'h0027, 16'h100C, 1'b0, 4'd8},
      '{1'b0, 8'd3,  8'hFF, 16'h0200, 16'h0041, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd12}, // R12
      '{1'b0, 8'd2,  8'hFF, 16'h0028, 16'h0200, 1'b1, 16'h0028, 16'h0201, 1'b0, 4'd2},  // R2
      '{1'b1, 8'd28, 8'h00, 16'hFD00, 16'h0201, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd8},  // R8 return
      '{1'b0, 8'd29, 8'h00, 16'h0000, 16'h100C, 1'b0, 16'h0000, 16'h0000, 1'b0, 4'd9}   // R9
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic rel, input logic [7:0] op, input logic [7:0] dst,
                        input logic [15:0] src);
      instr_data = {rel, op, dst, src};
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   always @(posedge clk) cycles++;

   initial begin
      drive(1'b0, 8'd2, 8'h01, 16'h0010);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R1: idle after reset, store opcode ignored
      check("R1", {cs_we, alu_valid, done, instr_addr}, {1'b0, 1'b0, 1'b0, 16'h0000});
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;

      for (int i = 0; i < NV; i++) begin
         drive(TBL[i].rel, TBL[i].op, TBL[i].dst, TBL[i].src);
         #1;
         checks++;
         if ({instr_addr, cs_we, cs_we ? cs_addr : 16'h0, cs_we ? cs_wdata : 16'h0, alu_valid}
             !== {TBL[i].pc, TBL[i].we, TBL[i].addr, TBL[i].wd, TBL[i].alu}) begin
            fails++;
            $display("FAIL R%0d step %0d actual pc=%h we=%b a=%h d=%h alu=%b expected pc=%h we=%b a=%h d=%h alu=%b",
                     TBL[i].req, i, instr_addr, cs_we, cs_addr, cs_wdata, alu_valid,
                     TBL[i].pc, TBL[i].we, TBL[i].addr, TBL[i].wd, TBL[i].alu);
         end
         @(negedge clk);
      end

      // R9: halted, done set, pc held after its increment
      drive(1'b0, 8'd2, 8'h01, 16'h0030);
      #1;
      check("R9", {done, instr_addr}, {1'b1, 16'h100D});
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         drive(1'b0, (k == 0) ? 8'd2 : 8'd14, 8'h01, 16'h0030);
         #1;
         check("R9", {cs_we, alu_valid, done, instr_addr}, {1'b0, 1'b0, 1'b1, 16'h100D});
      end

      // R1: restart clears done, pc to 0, cells keep values
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      drive(1'b0, 8'd2, 8'h01, 16'h0031);
      #1;
      check("R1", {done, instr_addr, cs_we, cs_wdata}, {1'b0, 16'h0000, 1'b1, 16'h1245});
      @(negedge clk);
      #1;
      check("R2", {48'h0, instr_addr}, {48'h0, 16'h0001});

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule